// File: doc/BRIEF.md
# Status Word Update Unit

This block keeps a 16-bit processor status word. The five condition flags sit in the low bits. An execution unit can update them flag by flag, and an instruction can also write the status word directly. In each cycle the register takes at most one of these two updates. A direct write always wins.

For a condition update, every flag gets its own 3-bit mode. The mode says whether the flag keeps its value, is cleared, takes a logic combination of two operand bits, copies one operand bit, or takes that bit inverted. Flags with special-case rules are computed outside the block and loaded through the copy mode, with the value placed on operand A.

A direct write replaces the whole word, or one byte, or only the bits that a mask selects. When a direct write happens, the condition results of the same instruction are thrown away.

Top module: `stw_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the whole word to 0x0000 at the next rising edge.
- R2: When neither `wr_valid` nor `cf_valid` is high, the word keeps its value.
- R3: Flag bits: N is bit 0, C is bit 1, V is bit 2, Z is bit 3 and E is bit 4. Flag i reads its mode from `cf_mode[3i+2:3i]` and its operands from `cf_opa[i]` and `cf_opb[i]`.
- R4: Mode code 0 keeps the flag and mode code 1 clears it.
- R5: The two-operand modes are code 2 for NOR, code 3 for AND, code 4 for OR and code 5 for XOR, each applied to a and b.
- R6: Mode code 6 loads a. Mode code 7 loads the inverse of a.
- R7: A condition update never changes bits 15:5.
- R8: A word write (`wr_size`=0) loads `wr_data` into all 16 bits.
- R9: A byte write (`wr_size`=1) loads `wr_data[7:0]` into the selected byte and clears the other byte. `wr_byte_sel`=0 selects bits 7:0 and `wr_byte_sel`=1 selects bits 15:8.
- R10: A bit-field write (`wr_size`=2) loads `wr_data` only into the bits where `wr_mask` is 1. Every other bit, including any flag that is not selected, keeps its value.
- R11: When `wr_valid` is high, the condition update in that cycle is discarded.
- R12: A write with the reserved size code 3 leaves the word unchanged, and it still discards that cycle's condition update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cf_valid | input | 1 | Condition-flag update present |
| cf_mode | input | 15 | Per-flag mode, 3 bits per flag |
| cf_opa | input | 5 | Operand A bit for each flag |
| cf_opb | input | 5 | Operand B bit for each flag |
| wr_valid | input | 1 | Direct write to the status word |
| wr_size | input | 2 | 0 word, 1 byte, 2 bit field, 3 reserved |
| wr_byte_sel | input | 1 | Byte select for byte writes |
| wr_data | input | 16 | Write data |
| wr_mask | input | 16 | Bit select for bit-field writes |
| stw | output | 16 | Current status word |

## Verification
The assertions assume the following about the inputs:
- All inputs are at known values on every rising edge once reset is released.
- `wr_size` carries one of the four listed codes.

The checks for the modes apply only in cycles where `wr_valid` is low, so they never conflict with the rule that a direct write wins.

The bench drives every input from a task at the falling clock edge, so the inputs are steady on each rising edge. Its random phase draws each size code, including the reserved one, and each of the eight mode codes. It also covers cycles where both update kinds arrive together. The bit-field masks are chosen to cover the flag bits and also to avoid them.

// File: rtl/stw_reg.sv
module stw_reg #(
  parameter int W  = 16,
  parameter int NF = 5,
  parameter int MW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cf_valid,
  input  logic [NF*MW-1:0] cf_mode,
  input  logic [NF-1:0]   cf_opa,
  input  logic [NF-1:0]   cf_opb,
  input  logic            wr_valid,
  input  logic [1:0]      wr_size,
  input  logic            wr_byte_sel,
  input  logic [W-1:0]    wr_data,
  input  logic [W-1:0]    wr_mask,
  output logic [W-1:0]    stw
);
  localparam int BW = W / 2;
  localparam logic [MW-1:0] M_KEEP = 0, M_CLR = 1, M_NOR = 2, M_AND = 3,
                            M_OR = 4, M_XOR = 5, M_CPY = 6, M_INV = 7;

  logic [W-1:0]  q;
  logic [NF-1:0] flg_nx;
  logic [W-1:0]  wr_nx;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic [MW-1:0] md;
    logic a, b;
    assign md = cf_mode[i*MW +: MW];
    assign a  = cf_opa[i];
    assign b  = cf_opb[i];
    always_comb begin
      case (md)
        M_KEEP:  flg_nx[i] = q[i];
        M_CLR:   flg_nx[i] = 1'b0;
        M_NOR:   flg_nx[i] = ~(a | b);
        M_AND:   flg_nx[i] = a & b;
        M_OR:    flg_nx[i] = a | b;
        M_XOR:   flg_nx[i] = a ^ b;
        M_CPY:   flg_nx[i] = a;
        M_INV:   flg_nx[i] = ~a;
        default: flg_nx[i] = q[i];
      endcase
    end
  end

  always_comb begin
    case (wr_size)
      2'd0:    wr_nx = wr_data;
      2'd1:    wr_nx = wr_byte_sel ? {wr_data[BW-1:0], {BW{1'b0}}}
                                   : {{BW{1'b0}}, wr_data[BW-1:0]};
      2'd2:    wr_nx = (q & ~wr_mask) | (wr_data & wr_mask);
      default: wr_nx = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (wr_valid) q <= wr_nx;
    else if (cf_valid) q[NF-1:0] <= flg_nx;
  end

  assign stw = q;
endmodule

// File: rtl/stw_chk.sv
module stw_chk #(
  parameter int W  = 16,
  parameter int NF = 5,
  parameter int MW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cf_valid,
  input logic [NF*MW-1:0] cf_mode,
  input logic [NF-1:0]    cf_opa,
  input logic [NF-1:0]    cf_opb,
  input logic             wr_valid,
  input logic [1:0]       wr_size,
  input logic             wr_byte_sel,
  input logic [W-1:0]     wr_data,
  input logic [W-1:0]     wr_mask,
  input logic [W-1:0]     stw
);
  localparam int BW = W / 2;

  assert_reset_R1: assert property (@(posedge clk) rst |=> stw == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !cf_valid) |=> $stable(stw));

  assert_upper_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(stw[W-1:NF]));

  assert_word_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size == 2'd0) |=> stw == $past(wr_data));

  assert_byte_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size == 2'd1) |=>
      (($past(wr_byte_sel) ? stw[BW-1:0] : stw[W-1:BW]) == '0));

  assert_field_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size == 2'd2) |=>
      ((stw ^ $past(stw)) & ~$past(wr_mask)) == '0);

  assert_reserved_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size == 2'd3) |=> $stable(stw));

  for (genvar i = 0; i < NF; i++) begin : g_fc
    assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && cf_valid && cf_mode[i*MW +: MW] == 3'd0) |=> $stable(stw[i]));
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && cf_valid && cf_mode[i*MW +: MW] == 3'd1) |=> !stw[i]);
    assert_and_R5: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && cf_valid && cf_mode[i*MW +: MW] == 3'd3) |=>
        stw[i] == $past(cf_opa[i] & cf_opb[i]));
    assert_copy_R6: assert property (@(posedge clk) disable iff (rst)
      (!wr_valid && cf_valid && cf_mode[i*MW +: MW] == 3'd6) |=>
        stw[i] == $past(cf_opa[i]));
  end
endmodule

bind stw_reg stw_chk #(.W(W), .NF(NF), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .cf_valid(cf_valid), .cf_mode(cf_mode),
  .cf_opa(cf_opa), .cf_opb(cf_opb), .wr_valid(wr_valid), .wr_size(wr_size),
  .wr_byte_sel(wr_byte_sel), .wr_data(wr_data), .wr_mask(wr_mask), .stw(stw));

// File: tb/test_stw_reg.sv
`timescale 1ns/1ps
module test_stw_reg;
  logic        clk = 0, rst = 1;
  logic        cf_valid = 0, wr_valid = 0, wr_byte_sel = 0;
  logic [14:0] cf_mode = '0;
  logic [4:0]  cf_opa = '0, cf_opb = '0;
  logic [1:0]  wr_size = '0;
  logic [15:0] wr_data = '0, wr_mask = '0, stw;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] m = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  stw_reg i_stw_reg (.clk(clk), .rst(rst), .cf_valid(cf_valid), .cf_mode(cf_mode),
    .cf_opa(cf_opa), .cf_opb(cf_opb), .wr_valid(wr_valid), .wr_size(wr_size),
    .wr_byte_sel(wr_byte_sel), .wr_data(wr_data), .wr_mask(wr_mask), .stw(stw));

  function automatic logic [15:0] model(input logic [15:0] o, input logic wv,
      input logic [1:0] sz, input logic sel, input logic [15:0] d, input logic [15:0] mk,
      input logic cv, input logic [14:0] md, input logic [4:0] a, input logic [4:0] b);
    logic [15:0] n;
    n = o;
    if (wv) begin
      if (sz == 0) n = d;
      else if (sz == 1) n = sel ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
      else if (sz == 2) n = (o & ~mk) | (d & mk);
    end else if (cv) begin
      for (int i = 0; i < 5; i++)
        case (md[i*3 +: 3])
          3'd1: n[i] = 1'b0;
          3'd2: n[i] = ~(a[i] | b[i]);
          3'd3: n[i] = a[i] & b[i];
          3'd4: n[i] = a[i] | b[i];
          3'd5: n[i] = a[i] ^ b[i];
          3'd6: n[i] = a[i];
          3'd7: n[i] = ~a[i];
          default: n[i] = o[i];
        endcase
    end
    return n;
  endfunction

  task automatic step(input logic wv, input logic [1:0] sz, input logic sel,
      input logic [15:0] d, input logic [15:0] mk, input logic cv,
      input logic [14:0] md, input logic [4:0] a, input logic [4:0] b, input string tag);
    @(negedge clk);
    rst = 0; wr_valid = wv; wr_size = sz; wr_byte_sel = sel; wr_data = d;
    wr_mask = mk; cf_valid = cv; cf_mode = md; cf_opa = a; cf_opb = b;
    m = model(m, wv, sz, sel, d, mk, cv, md, a, b);
    exp_q.push_back(m); tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_valid = 0; cf_valid = 0;
    m = '0;
    exp_q.push_back(m); tag_q.push_back("R1");
  endtask

  function automatic logic [14:0] all_modes(input logic [2:0] c);
    return {c, c, c, c, c};
  endfunction

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (stw !== e) begin
        fails++;
        $display("FAIL %s: stw=%h expected=%h", t, stw, e);
      end
    end
  end

  initial begin
    do_reset();
    step(0, 0, 0, 16'h0, 16'h0, 0, '0, '0, '0, "R2");
    step(1, 0, 0, 16'hA5F3, 16'h0, 0, '0, '0, '0, "R8");
    step(0, 0, 0, 16'h0, 16'h0, 0, '0, '0, '0, "R2");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd0), 5'h1F, 5'h1F, "R4");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd1), 5'h1F, 5'h1F, "R4 R7");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd2), 5'b00101, 5'b00011, "R5");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd3), 5'b10101, 5'b00111, "R5");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd4), 5'b10001, 5'b01000, "R5");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd5), 5'b11001, 5'b01010, "R5");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd6), 5'b01101, 5'b0, "R6");
    step(0, 0, 0, 16'h0, 16'h0, 1, all_modes(3'd7), 5'b01101, 5'b0, "R6");
    step(0, 0, 0, 16'h0, 16'h0, 1, {3'd6, 3'd1, 3'd7, 3'd0, 3'd3}, 5'b10001, 5'b00001, "R3");
    step(1, 1, 0, 16'h3C77, 16'h0, 0, '0, '0, '0, "R9");
    step(1, 1, 1, 16'h0099, 16'h0, 0, '0, '0, '0, "R9");
    step(1, 2, 0, 16'hFFFF, 16'h0F00, 0, '0, '0, '0, "R10 no flag");
    step(1, 2, 0, 16'h0000, 16'h0005, 0, '0, '0, '0, "R10 flag bits");
    step(1, 2, 0, 16'h0012, 16'h0018, 1, all_modes(3'd1), '0, '0, "R11");
    step(1, 0, 0, 16'h0000, 16'h0, 1, all_modes(3'd7), '0, '0, "R11");
    step(1, 3, 1, 16'hFFFF, 16'hFFFF, 1, all_modes(3'd7), '0, '0, "R12");
    step(1, 0, 0, 16'h1234, 16'h0, 0, '0, '0, '0, "R8");
    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic [15:0] mk;
      mk = ($urandom % 2) ? 16'($urandom) : (($urandom % 2) ? 16'h001F : 16'hFFE0);
      step($urandom % 3 == 0, 2'($urandom), 1'($urandom), 16'($urandom), mk,
           $urandom % 4 != 0, 15'($urandom), 5'($urandom), 5'($urandom), "R3 random");
    end
    @(negedge clk);
    wr_valid = 0; cf_valid = 0;
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: stw=%h expected=done", stw);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule